// File: doc/BRIEF.md
# ADC Clock Prescaler and Acquisition Timer

This block turns one high-speed peripheral clock into the two timing strobes that a converter core needs, and it times the sample-and-hold window. Every derived clock is a one-cycle enable pulse in the input clock domain, so the whole block and its users stay on a single clock net. The first stage makes the functional-clock enable. A 4-bit divider setting of zero passes the input clock straight through. Any other setting N gives one pulse every 2N input cycles. The second stage makes the conversion-clock enable. It either follows every functional pulse or keeps only every second one.

The acquisition timer opens a sample window on a start strobe and closes it after a programmed number of conversion-clock periods, plus one. It then gives a one-cycle done pulse. Divider settings are taken up only at the end of a divider period, so a change never produces a short period. A module reset request clears all of the logic once and then lets it run again, with no need to release the request.

Top module: `adc_clk_acq`

## Requirements
- R1: While `rst_n` is low, `fclk_en`, `conv_clk_en`, `acq_active` and `acq_done` are 0. In the first cycle after the first rising edge with `rst_n` high, `fclk_en` and `conv_clk_en` both pulse.
- R2: With `clk_div_sel` = 0 in use, `fclk_en` is high in every cycle. With `clk_div_sel` = N (1..15), it pulses once every 2N input cycles.
- R3: With `conv_div2` = 0 in use, `conv_clk_en` pulses with every `fclk_en` pulse. With `conv_div2` = 1, it pulses on every second `fclk_en` pulse only, and never without `fclk_en`.
- R4: With `clk_div_sel` = 6 and `conv_div2` = 0, `conv_clk_en` pulses every 12 input cycles (150 MHz in gives 12.5 MHz).
- R5: A new `clk_div_sel` or `conv_div2` value is sampled only in the cycle of that stage's own pulse. An interval that is already running completes with the old setting.
- R6: A `sample_start` seen while `acq_active` is 0 raises `acq_active` in the next cycle. `acq_active` stays high up to and including the cycle of the (`acq_len`+1)-th `conv_clk_en` pulse after it rose, then falls. `acq_len` is sampled only with the accepted start.
- R7: `acq_done` is high for exactly one cycle: the first cycle in which `acq_active` is low again after a completed window.
- R8: A `sample_start` that arrives while `acq_active` is high is ignored. It neither lengthens the window nor starts a second one.
- R9: A rising edge on `mod_rst_req` gives one clear cycle in which both enables are 0. After that cycle the window is aborted with no `acq_done`, and the dividers restart as in R1. Holding the request high has no further effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-speed peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_rst_req | input | 1 | Module reset request, acts on its rising edge |
| clk_div_sel | input | 4 | Functional prescale: 0 = bypass, N = divide by 2N |
| conv_div2 | input | 1 | Conversion prescale: 0 = divide by 1, 1 = divide by 2 |
| acq_len | input | 4 | Window length minus one, in conversion clock periods |
| sample_start | input | 1 | Start-of-sample strobe |
| fclk_en | output | 1 | Functional clock enable pulse |
| conv_clk_en | output | 1 | Conversion clock enable pulse |
| acq_active | output | 1 | Sample window open |
| acq_done | output | 1 | One-cycle window-complete pulse |

## Verification
The hardest situation to reach from the ports is a prescale change that lands in the middle of a divider period. The bench syncs to an `fclk_en` pulse, lets a few cycles pass, and only then changes `clk_div_sel`. It measures the interval that is already running and then the one after it, so an early take-up would show as a short gap. The module-reset abort is reached the same way: the bench opens a long window with a long `acq_len` and raises the request partway through. Over the cycles that follow, it counts `fclk_en` pulses and watches `acq_done`.

// File: rtl/adc_clk_acq_pkg.sv
package adc_clk_acq_pkg;

  // Input cycles between functional-clock pulses for a prescale setting.
  function automatic int fclk_period(input int sel);
    return (sel == 0) ? 1 : 2 * sel;
  endfunction

  // Functional pulses per conversion pulse.
  function automatic int conv_ratio(input logic half);
    return half ? 2 : 1;
  endfunction

endpackage

// File: rtl/adc_fclk_div.sv
module adc_fclk_div #(
  parameter int SEL_W = 4,
  parameter int CNT_W = SEL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [SEL_W-1:0] sel_in,
  output logic             tick,
  output logic [SEL_W-1:0] sel_used
);
  import adc_clk_acq_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] limit;
  logic             terminal;

  always_comb begin
    limit    = CNT_W'(fclk_period(int'(sel_q)) - 1);
    terminal = (cnt_q == limit);
  end

  assign tick     = run & terminal & ~clr;
  assign sel_used = sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else if (run) begin
      if (terminal) begin
        cnt_q <= '0;
        sel_q <= sel_in;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_conv_div.sv
module adc_conv_div (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic fclk_tick,
  input  logic half_in,
  output logic tick,
  output logic half_used
);

  logic phase_q;
  logic half_q;
  logic last;

  assign last      = ~half_q | phase_q;
  assign tick      = fclk_tick & last;
  assign half_used = half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      half_q  <= 1'b0;
    end else if (clr) begin
      phase_q <= 1'b0;
      half_q  <= 1'b0;
    end else if (fclk_tick) begin
      if (last) begin
        phase_q <= 1'b0;
        half_q  <= half_in;
      end else begin
        phase_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_acq_timer.sv
module adc_acq_timer #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic             conv_tick,
  input  logic [LEN_W-1:0] len_in,
  output logic             active,
  output logic             done,
  output logic             last
);

  logic [LEN_W-1:0] rem_q;
  logic             active_q;
  logic             done_q;

  assign last   = active_q & conv_tick & (rem_q == '0);
  assign active = active_q;
  assign done   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (clr) begin
      rem_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last;
      if (!active_q && start) begin
        active_q <= 1'b1;
        rem_q    <= len_in;
      end else if (last) begin
        active_q <= 1'b0;
      end else if (active_q && conv_tick) begin
        rem_q <= rem_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_clk_acq.sv
module adc_clk_acq #(
  parameter int SEL_W = 4,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_rst_req,
  input  logic [SEL_W-1:0] clk_div_sel,
  input  logic             conv_div2,
  input  logic [LEN_W-1:0] acq_len,
  input  logic             sample_start,
  output logic             fclk_en,
  output logic             conv_clk_en,
  output logic             acq_active,
  output logic             acq_done
);
  localparam int CNT_W = SEL_W + 1;

  // Internal events, named for the checker.
  logic             soft_clr;
  logic             run_q;
  logic             req_d;
  logic             fclk_tick;
  logic             conv_tick;
  logic             win_last;
  logic [SEL_W-1:0] sel_used;
  logic             half_used;

  // A rising request gives one clear cycle; the flag drops by itself.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d    <= 1'b0;
      soft_clr <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      req_d    <= mod_rst_req;
      soft_clr <= mod_rst_req & ~req_d;
      run_q    <= 1'b1;
    end
  end

  adc_fclk_div #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_fdiv (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (soft_clr),
    .run      (run_q),
    .sel_in   (clk_div_sel),
    .tick     (fclk_tick),
    .sel_used (sel_used)
  );

  adc_conv_div u_cdiv (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (soft_clr),
    .fclk_tick (fclk_tick),
    .half_in   (conv_div2),
    .tick      (conv_tick),
    .half_used (half_used)
  );

  adc_acq_timer #(.LEN_W(LEN_W)) u_acq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (soft_clr),
    .start     (sample_start),
    .conv_tick (conv_tick),
    .len_in    (acq_len),
    .active    (acq_active),
    .done      (acq_done),
    .last      (win_last)
  );

  assign fclk_en     = fclk_tick;
  assign conv_clk_en = conv_tick;

endmodule

// File: rtl/adc_clk_acq_chk.sv
module adc_clk_acq_chk #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] clk_div_sel,
  input logic             fclk_en,
  input logic             conv_clk_en,
  input logic             acq_active,
  input logic             acq_done,
  input logic             soft_clr,
  input logic             win_last
);
  import adc_clk_acq_pkg::*;

  localparam int GW = SEL_W + 2;

  logic [GW-1:0] gap_q;
  logic [GW-1:0] exp_q;
  logic          armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= '0;
      exp_q   <= '0;
      armed_q <= 1'b0;
    end else if (soft_clr) begin
      gap_q   <= '0;
      armed_q <= 1'b0;
    end else if (fclk_en) begin
      armed_q <= 1'b1;
      gap_q   <= GW'(1);
      exp_q   <= GW'(fclk_period(int'(clk_div_sel)));
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_FCLK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (fclk_en && armed_q) |-> (gap_q == exp_q)); // R2

  AST_CONV_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    conv_clk_en |-> fclk_en); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    acq_done |=> !acq_done); // R7

  AST_DONE_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    acq_done |-> (!acq_active && $past(acq_active))); // R7

  AST_WINDOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_active && !win_last && !soft_clr) |=> acq_active); // R8

  AST_CLEAR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (!acq_active && !acq_done)); // R9

endmodule

bind adc_clk_acq adc_clk_acq_chk #(.SEL_W(SEL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clk_div_sel (clk_div_sel),
  .fclk_en     (fclk_en),
  .conv_clk_en (conv_clk_en),
  .acq_active  (acq_active),
  .acq_done    (acq_done),
  .soft_clr    (soft_clr),
  .win_last    (win_last)
);

// File: tb/sim_adc_clk_acq.sv
`timescale 1ns/1ps
module sim_adc_clk_acq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mod_rst_req = 1'b0;
  logic [3:0] clk_div_sel = '0;
  logic       conv_div2 = 1'b0;
  logic [3:0] acq_len = '0;
  logic       sample_start = 1'b0;
  logic       fclk_en, conv_clk_en, acq_active, acq_done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  adc_clk_acq u0 (
    .clk(clk), .rst_n(rst_n), .mod_rst_req(mod_rst_req),
    .clk_div_sel(clk_div_sel), .conv_div2(conv_div2), .acq_len(acq_len),
    .sample_start(sample_start), .fclk_en(fclk_en), .conv_clk_en(conv_clk_en),
    .acq_active(acq_active), .acq_done(acq_done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      failures = failures + 1;
      $display("FAIL watchdog expired actual=%0d expected=done", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic next_fclk(output int gap);
    gap = 0;
    do begin tick(); gap++; end while (!fclk_en && gap < 300);
  endtask

  task automatic next_conv(output int gap);
    gap = 0;
    do begin tick(); gap++; end while (!conv_clk_en && gap < 300);
  endtask

  // Opens one window and measures it. Returns active cycles, conversion
  // pulses seen while open, and done pulses up to a few cycles after it.
  task automatic run_window(input int len, input bit restrike,
                            output int act_cyc, output int pulses, output int dones);
    acq_len = 4'(len);
    sample_start = 1'b1;
    tick();
    sample_start = 1'b0;
    act_cyc = 0; pulses = 0; dones = 0;
    while (acq_active && act_cyc < 1000) begin
      act_cyc++;
      if (conv_clk_en) pulses++;
      if (acq_done) dones++;
      acq_len = 4'd15;                         // R6: not sampled mid-window
      sample_start = restrike && (act_cyc == 2); // R8: ignored start
      tick();
    end
    sample_start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (acq_done) dones++;
      if (k == 0) check(acq_done == 1'b1, "R7 done in first idle cycle", acq_done, 1);
      if (k > 0) check(acq_active == 1'b0, "R8 no restart after window", acq_active, 0);
      tick();
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    clk_div_sel = 4'd3;
    repeat (3) tick();
    check(!fclk_en && !conv_clk_en, "R1 enables low in reset", {fclk_en, conv_clk_en}, 0);
    check(!acq_active && !acq_done, "R1 window idle in reset", {acq_active, acq_done}, 0);
    rst_n = 1'b1;
    tick();
    check(fclk_en && conv_clk_en, "R1 first pulse after release", {fclk_en, conv_clk_en}, 3);
    begin int g; next_fclk(g); check(g == 6, "R1 sel 3 gap", g, 6); end
  endtask

  task automatic t_fclk;
    int g;
    clk_div_sel = 4'd0;
    next_fclk(g);
    for (int i = 0; i < 3; i++) begin
      next_fclk(g); check(g == 1, "R2 bypass gap", g, 1);
    end
    clk_div_sel = 4'd5;
    next_fclk(g);
    next_fclk(g); check(g == 10, "R2 sel 5 gap", g, 10);
    clk_div_sel = 4'd15;
    next_fclk(g);
    next_fclk(g); check(g == 30, "R2 sel 15 gap", g, 30);
  endtask

  task automatic t_change;
    int g;
    repeat (3) tick();
    clk_div_sel = 4'd2;
    next_fclk(g); check(g + 3 == 30, "R5 running interval keeps old", g + 3, 30);
    next_fclk(g); check(g == 4, "R5 new setting next interval", g, 4);
  endtask

  task automatic t_conv;
    int g;
    clk_div_sel = 4'd6; conv_div2 = 1'b0;
    next_conv(g); next_conv(g);
    next_conv(g); check(g == 12, "R4 12.5 MHz from 150 MHz", g, 12);
    conv_div2 = 1'b1;
    next_conv(g);
    next_conv(g); check(g == 24, "R3 half rate gap", g, 24);
    check(fclk_en == 1'b1, "R3 conv pulse on fclk pulse", fclk_en, 1);
    next_fclk(g);
    check(g == 12 && !conv_clk_en, "R3 skipped fclk pulse", {g, 24'(conv_clk_en)}, 12);
    repeat (2) tick();
    conv_div2 = 1'b0;
    next_conv(g); check(g == 10, "R5 conv interval keeps halving", g, 10);
    next_conv(g); check(g == 12, "R5 conv new ratio", g, 12);
  endtask

  task automatic t_window;
    int a, p, d, g;
    clk_div_sel = 4'd0; conv_div2 = 1'b0;
    next_conv(g); next_conv(g);
    run_window(3, 1'b0, a, p, d);
    check(a == 4, "R6 len 3 active cycles", a, 4);
    check(d == 1, "R7 single done", d, 1);
    clk_div_sel = 4'd2; conv_div2 = 1'b1;
    next_conv(g); next_conv(g);
    run_window(2, 1'b0, a, p, d);
    check(p == 3, "R6 len 2 conv pulses", p, 3);
    check(d == 1, "R7 single done divided", d, 1);
    clk_div_sel = 4'd0; conv_div2 = 1'b0;
    next_conv(g); next_conv(g); next_conv(g);
    run_window(4, 1'b1, a, p, d);
    check(a == 5, "R8 restrike does not extend", a, 5);
    check(d == 1, "R8 one done only", d, 1);
  endtask

  task automatic t_modrst;
    int f, d;
    acq_len = 4'd12;
    sample_start = 1'b1;
    tick();
    sample_start = 1'b0;
    repeat (3) tick();
    mod_rst_req = 1'b1;
    tick();
    check(!fclk_en && !conv_clk_en, "R9 clear cycle enables low", {fclk_en, conv_clk_en}, 0);
    tick();
    check(!acq_active, "R9 window aborted", acq_active, 0);
    check(fclk_en && conv_clk_en, "R9 dividers restart", {fclk_en, conv_clk_en}, 3);
    f = 0; d = 0;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (fclk_en) f++;
      if (acq_done || acq_active) d++;
    end
    check(f == 20, "R9 held request no second clear", f, 20);
    check(d == 0, "R9 no done after abort", d, 0);
    mod_rst_req = 1'b0;
  endtask

  initial begin
    t_reset();
    t_fclk();
    t_change();
    t_conv();
    t_window();
    t_modrst();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule